// File: doc/BRIEF.md
# Power-Down Clock Gate and Wake Controller

This block decides when the internal clock of a serial bus interface may stop and when it must start again. The host asks for low power by setting a power-down bit during a control transfer. The request is honoured only when the bus is idle, or when the transfer is the first one since reset. The clock enable drops at the end of that transfer, not at the write strobe. While the block sleeps it watches three wake sources, each through a synchronizer on the free-running clock: the receive line going low, a rising edge on the status strobe, and the ready line going high. Any one of them turns the clock enable back on.

After a wake the controller opens a short check window and samples a valid-edge flag from the receive filter. If the flag arrives inside the window, normal operation continues. If it does not, the wake is treated as spurious. The controller then sends a one-cycle restart pulse to the protocol machine and holds the idle pin high for a fixed number of cycles. By monitoring the idle pin, the host can tell whether sleep was really entered.

Top module: `pdw_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, clk_en_o is 1 and pd_o, idle_pin_o and restart_o are 0 (with bus_busy_i low).
- R2: A control write with ctrl_pd_i=1 is accepted only if bus_busy_i is 0 or it is the first control write since reset. Any other such write is ignored: pd_o stays 0 and the clock is not gated.
- R3: After an accepted request, pd_o reads 1 from the next cycle on. clk_en_o stays 1 until ctrl_end_i is seen and is 0 from the cycle after it. While clk_en_o is 0, pd_o is 1.
- R4: While asleep, rx_i at 0 sets clk_en_o back to 1 exactly SYNC_STAGES+1 cycles later (3 by default).
- R5: While asleep, a 0-to-1 edge on stat_i wakes with the same latency as R4. A stat_i held at 1 from before sleep, or a falling stat_i, does not wake.
- R6: rdy_i at 1 while asleep wakes with the latency of R4. rdy_i at 1 between the accepted write and ctrl_end_i cancels the gating, so clk_en_o never drops.
- R7: If valid_edge_i is 1 in any of the first CHECK_CYC cycles (4 by default) after the clock returns, operation resumes with no restart pulse and no idle pulse.
- R8: If no valid edge arrives in that window, restart_o pulses for exactly one cycle, CHECK_CYC cycles after the clock returns. idle_pin_o is high for exactly IDLE_PULSE_CYC cycles (4 by default), starting in the cycle of the restart pulse. A late valid edge does not shorten this.
- R9: pd_o reads 0 from the cycle in which clk_en_o returns to 1 after any wake.
- R10: Outside a restart pulse, idle_pin_o follows bus_busy_i with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_pd_i | input | 1 | Power-down bit of the written control word |
| ctrl_end_i | input | 1 | End of the control transfer |
| bus_busy_i | input | 1 | Protocol machine's idle indicator (1 = not idle) |
| rx_i | input | 1 | Asynchronous receive line, low wakes |
| stat_i | input | 1 | Asynchronous status strobe, rising edge wakes |
| rdy_i | input | 1 | Asynchronous ready line, high wakes |
| valid_edge_i | input | 1 | Receive filter reports a genuine edge |
| clk_en_o | output | 1 | Enable for the gated internal clock |
| pd_o | output | 1 | Power-down status bit |
| idle_pin_o | output | 1 | Idle pin drive |
| restart_o | output | 1 | One-cycle restart request to the protocol machine |

## Verification
The bench tests the acceptance rule in both directions: the first transfer after reset is accepted while the bus is busy, and a later one is refused. A design that got this wrong would either refuse the first request or gate the clock in the middle of a message. It holds the status strobe high across sleep entry and then drops it. A controller that wakes on level instead of edge would wake on the held level and never sleep. It raises the ready line before a request to confirm that the clock never stops. Across random wake sources and valid-edge delays, it counts the restart and idle pulse cycles exactly. An off-by-one window would either restart after a genuine edge or miss a late spurious wake.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_ARMED,
    ST_SLEEP,
    ST_CHECK,
    ST_RESTART
  } pdw_state_e;
endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdw_wake_det.sv
module pdw_wake_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  input  logic stat_i,
  input  logic rdy_i,
  output logic wake_o
);
  logic rx_s, stat_s, rdy_s, stat_d;

  pdw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst(rst), .d(rx_i), .q(rx_s));
  pdw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stat_sync (
    .clk(clk), .rst(rst), .d(stat_i), .q(stat_s));
  pdw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .rst(rst), .d(rdy_i), .q(rdy_s));

  always_ff @(posedge clk) begin
    if (rst) stat_d <= 1'b0;
    else     stat_d <= stat_s;
  end

  // low receive level, rising strobe, or high ready
  assign wake_o = !rx_s || (stat_s && !stat_d) || rdy_s;
endmodule

// File: rtl/pdw_fsm.sv
module pdw_fsm
  import pdw_pkg::*;
#(
  parameter int CHECK_CYC      = 4,
  parameter int IDLE_PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr_i,
  input  logic ctrl_pd_i,
  input  logic ctrl_end_i,
  input  logic bus_busy_i,
  input  logic wake_i,
  input  logic valid_edge_i,
  output logic clk_en_o,
  output logic pd_o,
  output logic idle_pin_o,
  output logic restart_o
);
  localparam int MAX_CYC = (CHECK_CYC > IDLE_PULSE_CYC) ? CHECK_CYC : IDLE_PULSE_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] CHK_LAST  = CNT_W'(CHECK_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_PULSE_CYC - 1);

  pdw_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             first_q;
  logic             accept;

  assign accept = ctrl_wr_i && ctrl_pd_i && (!bus_busy_i || first_q);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      ST_RUN:   if (accept) state_n = ST_ARMED;
      ST_ARMED: begin
        if (wake_i) begin
          state_n = ST_CHECK;
          cnt_n   = '0;
        end else if (ctrl_end_i) begin
          state_n = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wake_i) begin
          state_n = ST_CHECK;
          cnt_n   = '0;
        end
      end
      ST_CHECK: begin
        if (valid_edge_i) begin
          state_n = ST_RUN;
        end else if (cnt == CHK_LAST) begin
          state_n = ST_RESTART;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_RESTART: begin
        if (cnt == IDLE_LAST) state_n = ST_RUN;
        else                  cnt_n   = cnt + 1'b1;
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      cnt        <= '0;
      first_q    <= 1'b1;
      clk_en_o   <= 1'b1;
      pd_o       <= 1'b0;
      idle_pin_o <= 1'b0;
      restart_o  <= 1'b0;
    end else begin
      state      <= state_n;
      cnt        <= cnt_n;
      if (ctrl_wr_i) first_q <= 1'b0;
      clk_en_o   <= (state_n != ST_SLEEP);
      pd_o       <= (state_n == ST_ARMED) || (state_n == ST_SLEEP);
      idle_pin_o <= bus_busy_i || (state_n == ST_RESTART);
      restart_o  <= (state_n == ST_RESTART) && (state != ST_RESTART);
    end
  end

  AST_GATE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_o) |-> $past(ctrl_end_i)); // R3
  AST_GATED_MEANS_PD: assert property (@(posedge clk) disable iff (rst)
    !clk_en_o |-> pd_o); // R3
  AST_WAKE_OPENS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && wake_i) |=> clk_en_o); // R4
  AST_WAKE_CLEARS_PD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && wake_i) |=> !pd_o); // R9
  AST_VALID_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHECK && valid_edge_i) |=> !restart_o); // R7
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o); // R8
  AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> idle_pin_o); // R8
endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl #(
  parameter int SYNC_STAGES    = 2,
  parameter int CHECK_CYC      = 4,
  parameter int IDLE_PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr_i,
  input  logic ctrl_pd_i,
  input  logic ctrl_end_i,
  input  logic bus_busy_i,
  input  logic rx_i,
  input  logic stat_i,
  input  logic rdy_i,
  input  logic valid_edge_i,
  output logic clk_en_o,
  output logic pd_o,
  output logic idle_pin_o,
  output logic restart_o
);
  logic wake;

  pdw_wake_det #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst(rst), .rx_i(rx_i), .stat_i(stat_i), .rdy_i(rdy_i),
    .wake_o(wake));

  pdw_fsm #(.CHECK_CYC(CHECK_CYC), .IDLE_PULSE_CYC(IDLE_PULSE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr_i), .ctrl_pd_i(ctrl_pd_i),
    .ctrl_end_i(ctrl_end_i), .bus_busy_i(bus_busy_i), .wake_i(wake),
    .valid_edge_i(valid_edge_i), .clk_en_o(clk_en_o), .pd_o(pd_o),
    .idle_pin_o(idle_pin_o), .restart_o(restart_o));
endmodule

// File: tb/pdw_ctrl_tb.sv
module pdw_ctrl_tb;
  localparam int SYNC = 2;
  localparam int CHK  = 4;
  localparam int IPC  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, ctrl_wr, ctrl_pd, ctrl_end, bus_busy, rx, stat, rdy, valid_edge;
  logic clk_en, pd, idle_pin, restart;
  int n_chk = 0;
  int n_fail = 0;

  pdw_ctrl #(.SYNC_STAGES(SYNC), .CHECK_CYC(CHK), .IDLE_PULSE_CYC(IPC)) u_dut (
    .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .ctrl_pd_i(ctrl_pd),
    .ctrl_end_i(ctrl_end), .bus_busy_i(bus_busy), .rx_i(rx), .stat_i(stat),
    .rdy_i(rdy), .valid_edge_i(valid_edge), .clk_en_o(clk_en), .pd_o(pd),
    .idle_pin_o(idle_pin), .restart_o(restart));

  function automatic int exp_restarts(input int d);
    return (d >= CHK) ? 1 : 0;
  endfunction
  function automatic int exp_idle(input int d);
    return exp_restarts(d) * IPC;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pd_write(input logic busy, input logic pdbit);
    bus_busy = busy; ctrl_wr = 1'b1; ctrl_pd = pdbit;
    step(1);
    ctrl_wr = 1'b0; ctrl_pd = 1'b0;
  endtask

  task automatic xfer_end();
    ctrl_end = 1'b1;
    step(1);
    ctrl_end = 1'b0;
  endtask

  task automatic drive_wake(input int src);
    case (src)
      0:       rx = 1'b0;
      1:       stat = 1'b1;
      default: rdy = 1'b1;
    endcase
  endtask

  task automatic release_src();
    rx = 1'b1; stat = 1'b0; rdy = 1'b0;
  endtask

  // Starts with the clock just restored; valid edge pulsed at offset d.
  task automatic watch(input int d, output int nrst, output int nidle, output int first);
    nrst = 0; nidle = 0; first = -1;
    for (int i = 0; i < 14; i++) begin
      valid_edge = (i == d);
      step(1);
      if (restart) begin
        if (nrst == 0) first = i;
        nrst++;
      end
      if (idle_pin) nidle++;
    end
    valid_edge = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int nr, ni, fi, zeros;
    void'($urandom(32'h5eed_0001));
    rst = 1'b1; ctrl_wr = 0; ctrl_pd = 0; ctrl_end = 0; bus_busy = 0;
    rx = 1'b1; stat = 0; rdy = 0; valid_edge = 0;
    step(3);
    chk("R1 clk_en in reset", clk_en, 1);
    rst = 1'b0;
    step(1);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 pd", pd, 0);
    chk("R1 idle", idle_pin, 0);
    chk("R1 restart", restart, 0);

    bus_busy = 1'b1;
    step(1);
    chk("R10 idle follows busy", idle_pin, 1);

    // first transfer after reset accepted despite busy
    pd_write(1'b1, 1'b1);
    chk("R2 first transfer accepted", pd, 1);
    chk("R3 clock on before end", clk_en, 1);
    xfer_end();
    chk("R3 gated after end", clk_en, 0);
    chk("R3 pd while gated", pd, 1);
    bus_busy = 1'b0;
    step(4);
    chk("R3 stays gated", clk_en, 0);
    drive_wake(0);
    step(SYNC);
    chk("R4 not yet awake", clk_en, 0);
    step(1);
    chk("R4 rx low wakes", clk_en, 1);
    chk("R9 pd cleared", pd, 0);
    watch(0, nr, ni, fi);
    chk("R7 no restart after valid edge", nr, 0);
    chk("R7 no idle pulse", ni, 0);
    release_src();
    step(4);

    // busy and not first transfer: rejected
    bus_busy = 1'b1;
    pd_write(1'b1, 1'b1);
    chk("R2 busy request ignored pd", pd, 0);
    xfer_end();
    chk("R2 busy request ignored clk", clk_en, 1);
    bus_busy = 1'b0;
    step(3);

    // status strobe held high: level must not wake
    stat = 1'b1;
    step(4);
    pd_write(1'b0, 1'b1);
    xfer_end();
    step(6);
    chk("R5 held strobe no wake", clk_en, 0);
    stat = 1'b0;
    step(4);
    chk("R5 falling strobe no wake", clk_en, 0);
    drive_wake(1);
    step(SYNC);
    chk("R5 not yet awake", clk_en, 0);
    step(1);
    chk("R5 rising strobe wakes", clk_en, 1);
    watch(CHK + 2, nr, ni, fi);
    chk("R8 restart count", nr, 1);
    chk("R8 restart timing", fi, CHK - 1);
    chk("R8 idle pulse length", ni, IPC);
    release_src();
    step(4);

    // ready high during the transfer cancels gating
    rdy = 1'b1;
    step(4);
    pd_write(1'b0, 1'b1);
    chk("R6 armed pd", pd, 1);
    xfer_end();
    chk("R6 premature clear pd", pd, 0);
    zeros = (clk_en == 1'b0) ? 1 : 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (!clk_en) zeros++;
    end
    chk("R6 clock never gated", zeros, 0);
    release_src();
    step(6);

    for (int it = 0; it < 24; it++) begin
      int src, d, g;
      src = int'($urandom % 3);
      d   = int'($urandom % 7);
      g   = int'($urandom % 5) + 1;
      pd_write(1'b0, 1'b1);
      chk("R3 rand pd set", pd, 1);
      xfer_end();
      chk("R3 rand gated", clk_en, 0);
      step(g);
      chk("R3 rand stays gated", clk_en, 0);
      drive_wake(src);
      step(SYNC);
      chk(src == 0 ? "R4 rand early" : (src == 1 ? "R5 rand early" : "R6 rand early"), clk_en, 0);
      step(1);
      chk(src == 0 ? "R4 rand wake" : (src == 1 ? "R5 rand wake" : "R6 rand wake"), clk_en, 1);
      chk("R9 rand pd cleared", pd, 0);
      watch(d, nr, ni, fi);
      chk(d >= CHK ? "R8 rand restart" : "R7 rand restart", nr, exp_restarts(d));
      chk(d >= CHK ? "R8 rand idle" : "R7 rand idle", ni, exp_idle(d));
      if (exp_restarts(d) == 1) chk("R8 rand timing", fi, CHK - 1);
      release_src();
      step(4);
    end

    bus_busy = 1'b1;
    step(1);
    chk("R10 idle high", idle_pin, 1);
    bus_busy = 1'b0;
    step(1);
    chk("R10 idle low", idle_pin, 0);
    finish_run();
  end
endmodule